// File: doc/BRIEF.md
# SPI Slave Frame Receiver

This block receives data on the peripheral side of an SPI link. It treats every period in which the active-low select input is held low as one frame, and that frame may have any length. The serial clock, select and data inputs pass through a multi-flop synchroniser into the faster system clock. Each data bit is taken once, on the rising serial clock edge, with the most significant bit first. Every completed word is presented with a one-cycle strobe, and the first word of a frame carries a start flag.

When select returns high, the receiver pulses an end-of-frame output. With that pulse it reports whether the frame passed its CRC check and whether it ended partway through a word. The CRC covers the whole frame, including the CRC byte the sender appends last. A good frame therefore leaves a zero residue. All receive state is cleared whenever select is inactive. A missing or spurious clock edge can therefore spoil only the frame in progress, and the next frame is received correctly.

The control is a three-state machine:
- IDLE: deselected. State is cleared.
- RECV: select is active. Bits are shifted in.
- CLOSE: a single cycle that clears state after the end report.

It has three transitions:
- T_OPEN: IDLE to RECV, when synchronised select goes low.
- T_SHUT: RECV to CLOSE, when synchronised select goes high. The end report is issued on this transition.
- T_RETIRE: CLOSE to IDLE, unconditionally.

Top module: `spi_frame_rx`

## Requirements
- R1: After reset, rx_valid, rx_sof, rx_byte, frame_end, frame_crc_ok and frame_malformed are all 0.
- R2: While select is low, spi_mosi is sampled on each rising spi_sclk edge, and the first bit sampled becomes bit 7 of rx_byte (MSB first).
- R3: rx_valid is high for exactly one system clock for each completed 8-bit word, and never for a partial word.
- R4: rx_sof is 1 with the first word of a frame and 0 with every later word of that frame.
- R5: Each select-low period produces exactly one frame_end pulse, one system clock wide, after select returns high.
- R6: The CRC is CRC-8 with polynomial 0x07, processed MSB first with no reflection and no final XOR, starting from parameter CRC_INIT. It runs over every received word, including the final CRC word. frame_crc_ok is 1 exactly when the residue is zero, at least one word was received and no partial word remains.
- R7: If select rises when the bit count is not a multiple of 8, frame_malformed is 1, frame_crc_ok is 0, and the partial bits produce no rx_valid.
- R8: The bit counter, partial word and CRC register return to their idle values whenever select is inactive. A frame with an extra or missing clock edge therefore does not disturb the frame that follows.
- R9: There is no maximum frame length. A frame of 300 words is received and checked like a short one.
- R10: spi_sclk edges while select is high produce no rx_valid and no frame_end.
- R11: A frame with no clock edges gives a frame_end with frame_crc_ok = 0 and frame_malformed = 0.
- R12: A frame of whole words whose content was corrupted gives frame_crc_ok = 0 and frame_malformed = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the controller (mode 0) |
| spi_ss_n | input | 1 | Active-low select; sets the frame boundaries |
| spi_mosi | input | 1 | Serial data from the controller |
| rx_byte | output | DATA_W | Last completed word |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| rx_sof | output | 1 | rx_byte is the first word of its frame |
| frame_end | output | 1 | One-cycle pulse after select is released |
| frame_crc_ok | output | 1 | Frame passed the CRC and was well formed (valid with frame_end) |
| frame_malformed | output | 1 | Frame ended inside a word (valid with frame_end) |

## Verification
The bench builds the receiver with SYNC_STAGES = 3 and CRC_INIT = 0xFF, with DATA_W = 8 and polynomial 0x07 unchanged. The deeper synchroniser exercises the edge detector with extra latency. The non-zero seed value shows that the zero-residue test does not depend on a zero start value. With a serial clock at one eighth of the system clock, the bench reaches frames of zero to 300 words, one-bit short and long frames, and corrupted payloads. It also reaches clock activity while deselected and back-to-back frames after damaged ones.

// File: rtl/spi_frx_pkg.sv
package spi_frx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_CLOSE = 2'd2
    } frx_state_t;

    localparam int CRC_W = 8;

endpackage

// File: rtl/spi_frx_sync.sv
module spi_frx_sync #(
    parameter int              WIDTH     = 3,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RESET_VAL;
        else        pipe[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RESET_VAL;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_frx_crc.sv
module spi_frx_crc #(
    parameter int                 DATA_W = 8,
    parameter int                 CRC_W  = 8,
    parameter logic [CRC_W-1:0]   POLY   = 8'h07
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    function automatic logic [CRC_W-1:0] step_word(
        input logic [CRC_W-1:0]  c_in,
        input logic [DATA_W-1:0] w
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ w[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        return c;
    endfunction

    assign crc_out = step_word(crc_in, data_in);

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_frx_pkg::*;
#(
    parameter int               DATA_W      = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07,
    parameter logic [CRC_W-1:0] CRC_INIT    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_ss_n,
    input  logic              spi_mosi,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_sof,
    output logic              frame_end,
    output logic              frame_crc_ok,
    output logic              frame_malformed
);

    localparam int               CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    // synchronised pins: {sclk, ss_n, mosi}; ss_n idles high
    logic [2:0] pins_s;
    logic       sclk_s, ss_n_s, mosi_s, sclk_prev;
    logic       sclk_rise, ss_act;

    spi_frx_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_sclk, spi_ss_n, spi_mosi}),
        .q    (pins_s)
    );

    assign {sclk_s, ss_n_s, mosi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign ss_act    = ~ss_n_s;

    // receive datapath state
    frx_state_t        state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [CRC_W-1:0]  crc_q, crc_next;
    logic              first_q, got_word_q;
    logic [DATA_W-1:0] word_next;

    assign word_next = {shreg_q[DATA_W-2:0], mosi_s};

    spi_frx_crc #(
        .DATA_W(DATA_W),
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY)
    ) u_crc (
        .crc_in (crc_q),
        .data_in(word_next),
        .crc_out(crc_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_OPEN, T_SHUT, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ss_act)  state_d = ST_RECV;   // T_OPEN
            ST_RECV:  if (!ss_act) state_d = ST_CLOSE;  // T_SHUT
            ST_CLOSE:              state_d = ST_IDLE;   // T_RETIRE
            default:               state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q         <= '0;
            bit_cnt_q       <= '0;
            crc_q           <= CRC_INIT;
            first_q         <= 1'b1;
            got_word_q      <= 1'b0;
            rx_byte         <= '0;
            rx_valid        <= 1'b0;
            rx_sof          <= 1'b0;
            frame_end       <= 1'b0;
            frame_crc_ok    <= 1'b0;
            frame_malformed <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            frame_end <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_CLOSE: begin
                    shreg_q    <= '0;
                    bit_cnt_q  <= '0;
                    crc_q      <= CRC_INIT;
                    first_q    <= 1'b1;
                    got_word_q <= 1'b0;
                end
                ST_RECV: begin
                    if (!ss_act) begin
                        frame_end       <= 1'b1;
                        frame_malformed <= (bit_cnt_q != '0);
                        frame_crc_ok    <= (bit_cnt_q == '0) && got_word_q
                                           && (crc_q == '0);
                    end else if (sclk_rise) begin
                        shreg_q <= word_next;
                        if (bit_cnt_q == LAST_BIT) begin
                            bit_cnt_q  <= '0;
                            rx_byte    <= word_next;
                            rx_valid   <= 1'b1;
                            rx_sof     <= first_q;
                            first_q    <= 1'b0;
                            got_word_q <= 1'b1;
                            crc_q      <= crc_next;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // checks next to the logic they guard
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                       // R3
    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(state_q == ST_RECV && ss_act));             // R10
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);                                     // R5
    AST_END_AFTER_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> state_q == ST_CLOSE);                            // R5
    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !(frame_crc_ok && frame_malformed));             // R7
    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (bit_cnt_q == '0 && crc_q == CRC_INIT
                                  && first_q));                        // R8

endmodule

// File: tb/spi_frame_rx_tb.sv
module spi_frame_rx_tb;

    localparam int         HALF     = 4;
    localparam logic [7:0] T_POLY   = 8'h07;
    localparam logic [7:0] T_INIT   = 8'hFF;
    localparam int         BUF_N    = 512;
    localparam int         LOG_N    = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_ss_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_sof, frame_end, frame_crc_ok, frame_malformed;

    always #10 clk = ~clk;

    spi_frame_rx #(
        .DATA_W     (8),
        .SYNC_STAGES(3),
        .CRC_POLY   (T_POLY),
        .CRC_INIT   (T_INIT)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .spi_sclk       (spi_sclk),
        .spi_ss_n       (spi_ss_n),
        .spi_mosi       (spi_mosi),
        .rx_byte        (rx_byte),
        .rx_valid       (rx_valid),
        .rx_sof         (rx_sof),
        .frame_end      (frame_end),
        .frame_crc_ok   (frame_crc_ok),
        .frame_malformed(frame_malformed)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] tx_buf [BUF_N];
    logic [7:0] log_b  [LOG_N];
    logic       log_s  [LOG_N];
    int         n_valid = 0;
    int         n_end = 0;
    int         n_wide = 0;
    logic       prev_valid = 1'b0;
    logic       last_ok = 1'b0;
    logic       last_mal = 1'b0;

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (n_valid < LOG_N) begin
                    log_b[n_valid] <= rx_byte;
                    log_s[n_valid] <= rx_sof;
                end
                n_valid <= n_valid + 1;
                if (prev_valid) n_wide <= n_wide + 1;
            end
            prev_valid <= rx_valid;
            if (frame_end) begin
                n_end    <= n_end + 1;
                last_ok  <= frame_crc_ok;
                last_mal <= frame_malformed;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_word(input logic [7:0] c_in, input logic [7:0] d);
        logic [7:0] c;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ T_POLY;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [7:0] crc_span(input int n);
        logic [7:0] c;
        c = T_INIT;
        for (int i = 0; i < n; i++) c = crc_word(c, tx_buf[i]);
        return c;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // payload of len words plus a trailing CRC word; optional single-bit corruption
    task automatic build(input int len, input bit corrupt);
        int k;
        for (int i = 0; i < len; i++) tx_buf[i] = 8'($urandom_range(0, 255));
        tx_buf[len]     = crc_span(len);
        tx_buf[len + 1] = 8'($urandom_range(0, 255));
        if (corrupt) begin
            k = $urandom_range(0, len);
            tx_buf[k] = tx_buf[k] ^ (8'h01 << $urandom_range(0, 7));
        end
    endtask

    task automatic send(input int nbits);
        spi_ss_n = 1'b0;
        wait_clk(8);
        for (int k = 0; k < nbits; k++) begin
            spi_mosi = tx_buf[k / 8][7 - (k % 8)];
            wait_clk(HALF);
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
        wait_clk(4);
        spi_ss_n = 1'b1;
        wait_clk(14);
    endtask

    task automatic run_frame(input int nbits, input string tag);
        int  v0, e0, w0, exp_n, bad_b, bad_s;
        bit  exp_mal, exp_ok;
        v0 = n_valid; e0 = n_end; w0 = n_wide;
        send(nbits);
        exp_n   = nbits / 8;
        exp_mal = (nbits % 8) != 0;
        exp_ok  = !exp_mal && exp_n > 0 && crc_span(exp_n) == 8'h00;
        chk("R3", {tag, " word strobes"}, n_valid - v0, exp_n);
        chk("R3", {tag, " strobe width"}, n_wide - w0, 0);
        bad_b = 0; bad_s = 0;
        for (int i = 0; i < exp_n && (v0 + i) < LOG_N; i++) begin
            if (log_b[v0 + i] != tx_buf[i]) bad_b++;
            if (log_s[v0 + i] != (i == 0)) bad_s++;
        end
        chk("R2", {tag, " word mismatches"}, bad_b, 0);
        chk("R4", {tag, " sof mismatches"}, bad_s, 0);
        chk("R5", {tag, " end pulses"}, n_end - e0, 1);
        chk("R7", {tag, " malformed"}, int'(last_mal), int'(exp_mal));
        chk("R6", {tag, " crc ok"}, int'(last_ok), int'(exp_ok));
    endtask

    initial begin
        wait_clk(200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v0, e0, len, kind, nb;
        void'($urandom(32'd4711));
        wait_clk(5);
        chk("R1", "rx_valid after reset", int'(rx_valid), 0);
        chk("R1", "frame_end after reset", int'(frame_end), 0);
        chk("R1", "status after reset", int'({rx_sof, frame_crc_ok, frame_malformed}), 0);
        chk("R1", "rx_byte after reset", int'(rx_byte), 0);
        rst_n = 1'b1;
        wait_clk(6);

        // R10: clocks while deselected do nothing
        v0 = n_valid; e0 = n_end;
        for (int i = 0; i < 20; i++) begin
            spi_mosi = i[0];
            wait_clk(HALF); spi_sclk = 1'b1;
            wait_clk(HALF); spi_sclk = 1'b0;
        end
        wait_clk(10);
        chk("R10", "strobes while deselected", n_valid - v0, 0);
        chk("R10", "ends while deselected", n_end - e0, 0);

        // R2: fixed MSB-first pattern, one word plus CRC
        tx_buf[0] = 8'hA5; tx_buf[1] = crc_span(1); tx_buf[2] = 8'h3C;
        run_frame(16, "R2 fixed");

        // R11: empty frame
        run_frame(0, "R11 empty");

        // R12: corrupted payload
        build(6, 1'b1);
        run_frame(7 * 8, "R12 corrupt");

        // R7 / R8: missing edge, then a good frame
        build(5, 1'b0);
        run_frame(6 * 8 - 1, "R7 short");
        build(5, 1'b0);
        run_frame(6 * 8, "R8 after short");
        // extra edge, then a good frame
        build(4, 1'b0);
        run_frame(5 * 8 + 1, "R7 long");
        build(3, 1'b0);
        run_frame(4 * 8, "R8 after long");

        // R9: long frame
        build(299, 1'b0);
        run_frame(300 * 8, "R9 long frame");

        // random mix
        for (int f = 0; f < 24; f++) begin
            len  = $urandom_range(1, 24);
            kind = $urandom_range(0, 3);
            build(len, kind == 1);
            nb = (len + 1) * 8 + ((kind == 2) ? 1 : 0) - ((kind == 3) ? 1 : 0);
            run_frame(nb, "R6 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule